// File: doc/BRIEF.md
# Nonvolatile Write-Back Sequencer

This block decides when three volatile shadow bytes are copied into nonvolatile storage. The bus interface pulses `wr_done` once a write transaction has closed with its STOP condition. The sequencer then starts a write-back that always programs all three locations, even those the transaction did not touch. It holds `busy` high for a fixed write time measured in clock cycles. While `busy` is high, the bus interface refuses its device address, so a master either polls with address attempts or waits out the maximum write time.

When zero-crossing detection is enabled, programming is held off until the detection logic reports completion. The sequencer keeps a saturating wear counter per location. It freezes the data to be stored at the moment programming begins. A completion strobe that arrives during a cycle in progress is remembered and starts a fresh cycle afterwards.

The controller is a four-state machine:
- `ST_IDLE`: no request is outstanding.
- `ST_WAIT_ZC`: a request is committed but zero-crossing detection is still running.
- `ST_PROG`: the single strobe cycle, in which every location is programmed and the snapshot is presented.
- `ST_HOLD`: the remaining write time.

Its transitions are:
- IDLE→WAIT_ZC on a request while gated.
- IDLE→PROG on a request while not gated.
- WAIT_ZC→PROG once the gate opens.
- PROG→HOLD always.
- HOLD→IDLE when the write timer reaches zero.

Top module: `nvm_writeback_ctrl`

## Requirements
- R1: After reset `busy` is 0, `prog_strobe` is 0 and every wear counter is 0.
- R2: When `wr_done` is sampled 1 in idle and the zero-crossing gate is open, the next cycle has `busy`=1 and all three bits of `prog_strobe` set together. That strobe cycle lasts exactly one cycle, and every write-back strobes all three locations.
- R3: From the strobe cycle, `busy` stays 1 for exactly WRITE_CYCLES consecutive cycles (strobe cycle included) and then falls. It falls in the cycle after the write timer reaches zero.
- R4: The gate is closed when `zc_enable`=1 and `zc_done`=0. A request taken while the gate is closed raises `busy` with `prog_strobe`=0. The strobe cycle follows the first edge at which the gate is sampled open. `zc_done` has no effect while `zc_enable`=0.
- R5: `prog_data` equals `shadow_in` as sampled at the edge that enters the strobe cycle, and keeps that value until the next write-back starts, whatever `shadow_in` does meanwhile. Location i is bits [8i+7:8i].
- R6: A `wr_done` sampled while not idle is remembered. After `busy` falls it stays 0 for exactly one cycle, then a new strobe cycle starts.
- R7: Any number of `wr_done` strobes during one busy period yields exactly one extra write-back. Afterwards the block stays idle.
- R8: Each write-back adds one to the wear counter of every location. A counter saturates at 2^WEAR_W−1. Location i occupies bits [WEAR_W·i+WEAR_W−1 : WEAR_W·i] of `wear_count`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_done | input | 1 | One-cycle strobe: a write transaction ended with STOP |
| zc_enable | input | 1 | Zero-crossing detection is enabled |
| zc_done | input | 1 | Zero-crossing detection has completed |
| shadow_in | input | NUM_LOC*BYTE_W | Current volatile shadow bytes |
| busy | output | 1 | Write-back in progress; the device address must not be acknowledged |
| prog_strobe | output | NUM_LOC | Per-location programming strobe |
| prog_data | output | NUM_LOC*BYTE_W | Snapshot of the bytes being programmed |
| wear_count | output | NUM_LOC*WEAR_W | Per-location write-back counters |

## Verification
The hardest case to reach is a completion strobe that lands at a precise point inside a running write-back, in particular on its very last busy cycle. A strobe there is latched on the same edge at which the machine returns to idle. The bench reaches every position by starting a cycle and then sweeping the offset of a second `wr_done` pulse over each busy cycle in turn. In one sweep it adds a further pulse to show that the two coalesce. The zero-crossing wait is swept the same way, over several gate-open delays.

// File: rtl/nvwb_pkg.sv
package nvwb_pkg;
    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_WAIT_ZC = 2'd1,
        ST_PROG    = 2'd2,
        ST_HOLD    = 2'd3
    } nvwb_state_t;
endpackage

// File: rtl/nvwb_timer.sv
module nvwb_timer #(
    parameter int WRITE_CYCLES = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  logic run,
    output logic at_zero
);
    localparam int CW = (WRITE_CYCLES > 2) ? $clog2(WRITE_CYCLES) : 1;
    localparam logic [CW-1:0] LOAD_VAL = CW'(WRITE_CYCLES - 1);

    logic [CW-1:0] remain;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            remain <= '0;
        else if (load)
            remain <= LOAD_VAL;
        else if (run && remain != '0)
            remain <= remain - 1'b1;
    end

    assign at_zero = (remain == '0);

    AST_LOAD_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> !at_zero); // R3
endmodule

// File: rtl/nvwb_wear.sv
module nvwb_wear #(
    parameter int NUM_LOC = 3,
    parameter int WEAR_W  = 16
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [NUM_LOC-1:0]        inc,
    output logic [NUM_LOC*WEAR_W-1:0] wear_out
);
    localparam logic [WEAR_W-1:0] SAT = {WEAR_W{1'b1}};

    for (genvar i = 0; i < NUM_LOC; i++) begin : g_loc
        logic [WEAR_W-1:0] cnt;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                cnt <= '0;
            else if (inc[i] && cnt != SAT)
                cnt <= cnt + 1'b1;
        end

        assign wear_out[i*WEAR_W +: WEAR_W] = cnt;

        AST_WEAR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
            inc[i] && cnt != SAT |=> cnt == $past(cnt) + 1'b1); // R8
        AST_WEAR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
            !inc[i] |=> $stable(cnt)); // R8
    end
endmodule

// File: rtl/nvm_writeback_ctrl.sv
module nvm_writeback_ctrl #(
    parameter int NUM_LOC      = 3,
    parameter int BYTE_W       = 8,
    parameter int WRITE_CYCLES = 16,
    parameter int WEAR_W       = 16
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr_done,
    input  logic                      zc_enable,
    input  logic                      zc_done,
    input  logic [NUM_LOC*BYTE_W-1:0] shadow_in,
    output logic                      busy,
    output logic [NUM_LOC-1:0]        prog_strobe,
    output logic [NUM_LOC*BYTE_W-1:0] prog_data,
    output logic [NUM_LOC*WEAR_W-1:0] wear_count
);
    import nvwb_pkg::*;

    localparam int DW = NUM_LOC * BYTE_W;
    localparam int HW = $clog2(WRITE_CYCLES + 1);

    nvwb_state_t state, state_nx;
    logic        pending;
    logic        request;
    logic        zc_block;
    logic        tmr_zero;
    logic        enter_prog;
    logic [DW-1:0] snap;

    assign zc_block   = zc_enable && !zc_done;
    assign request    = wr_done || pending;
    assign enter_prog = (state_nx == ST_PROG) && (state != ST_PROG);

    // next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:    if (request) state_nx = zc_block ? ST_WAIT_ZC : ST_PROG;
            ST_WAIT_ZC: if (!zc_block) state_nx = ST_PROG;
            ST_PROG:    state_nx = ST_HOLD;
            ST_HOLD:    if (tmr_zero) state_nx = ST_IDLE;
            default:    state_nx = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state <= ST_IDLE;
        else
            state <= state_nx;
    end

    // request latch: strobes seen outside idle wait for the next cycle
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            pending <= 1'b0;
        else if (state == ST_IDLE)
            pending <= 1'b0;
        else if (wr_done)
            pending <= 1'b1;
    end

    // snapshot of the shadow bytes at the start of programming
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            snap <= '0;
        else if (enter_prog)
            snap <= shadow_in;
    end

    // outputs
    always_comb begin
        busy        = 1'b0;
        prog_strobe = '0;
        unique case (state)
            ST_IDLE:    busy = 1'b0;
            ST_WAIT_ZC: busy = 1'b1;
            ST_PROG: begin
                busy        = 1'b1;
                prog_strobe = '1;
            end
            ST_HOLD:    busy = 1'b1;
            default:    busy = 1'b0;
        endcase
    end

    assign prog_data = snap;

    nvwb_timer #(.WRITE_CYCLES(WRITE_CYCLES)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (enter_prog),
        .run     (state == ST_PROG || state == ST_HOLD),
        .at_zero (tmr_zero)
    );

    nvwb_wear #(.NUM_LOC(NUM_LOC), .WEAR_W(WEAR_W)) u_wear (
        .clk      (clk),
        .rst_n    (rst_n),
        .inc      (prog_strobe),
        .wear_out (wear_count)
    );

    // independent count of hold cycles, compared against the timer
    logic [HW-1:0] hold_seen;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            hold_seen <= '0;
        else if (state == ST_PROG)
            hold_seen <= '0;
        else if (state == ST_HOLD)
            hold_seen <= hold_seen + 1'b1;
    end

    AST_BUSY_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HOLD && tmr_zero) |-> hold_seen == HW'(WRITE_CYCLES - 2)); // R3
    AST_ALL_LOCATIONS: assert property (@(posedge clk) disable iff (!rst_n)
        (prog_strobe != '0) |-> (prog_strobe == '1)); // R2
    AST_SINGLE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        (prog_strobe != '0) |=> (prog_strobe == '0)); // R2
    AST_STROBE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (prog_strobe != '0) |-> busy); // R2
    AST_ZC_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(prog_strobe[0]) |-> $past(!zc_enable || zc_done)); // R4
    AST_SNAP_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HOLD) |-> $stable(prog_data)); // R5
    AST_NO_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && wr_done) |=> (pending || state == ST_IDLE && $past(state) == ST_IDLE)); // R6
endmodule

// File: tb/nvm_writeback_ctrl_bench.sv
module nvm_writeback_ctrl_bench;
    localparam int NL = 3;
    localparam int BW = 8;
    localparam int WC = 4;
    localparam int WW = 3;
    localparam int WMAX = (1 << WW) - 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wr_done = 1'b0;
    logic zc_enable = 1'b0;
    logic zc_done = 1'b0;
    logic [NL*BW-1:0] shadow_in = '0;
    logic busy;
    logic [NL-1:0] prog_strobe;
    logic [NL*BW-1:0] prog_data;
    logic [NL*WW-1:0] wear_count;

    int total = 0;
    int bad = 0;
    int nwb = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    nvm_writeback_ctrl #(.NUM_LOC(NL), .BYTE_W(BW), .WRITE_CYCLES(WC), .WEAR_W(WW)) u_nvm_writeback_ctrl (
        .clk(clk), .rst_n(rst_n), .wr_done(wr_done), .zc_enable(zc_enable),
        .zc_done(zc_done), .shadow_in(shadow_in), .busy(busy),
        .prog_strobe(prog_strobe), .prog_data(prog_data), .wear_count(wear_count)
    );

    task automatic tick;
        @(posedge clk);
        #2;
    endtask

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic chk_wear(input string req);
        int e;
        e = (nwb > WMAX) ? WMAX : nwb;
        for (int i = 0; i < NL; i++)
            chk(wear_count[i*WW +: WW] == WW'(e), req, wear_count[i*WW +: WW], e);
    endtask

    // we are in the strobe cycle; count busy cycles and check snapshot stability
    task automatic measure(input logic [NL*BW-1:0] exp_data);
        int len;
        len = 1;
        chk(prog_strobe == '1, "R2 strobe all", prog_strobe, 3'b111);
        chk(prog_data == exp_data, "R5 snapshot", prog_data, exp_data);
        nwb++;
        shadow_in = ~exp_data;
        for (int k = 0; k < 20; k++) begin
            tick;
            if (!busy) break;
            len++;
            if (prog_strobe != '0 || prog_data != exp_data)
                chk(0, "R2/R5 hold", {prog_strobe, prog_data}, {3'b000, exp_data});
        end
        chk(len == WC, "R3 busy length", len, WC);
    endtask

    task automatic pulse;
        wr_done = 1'b1;
        tick;
        wr_done = 1'b0;
    endtask

    initial begin
        logic [NL*BW-1:0] d;
        int lows;
        #1;
        tick;
        tick;
        chk(busy == 1'b0, "R1 busy", busy, 0);
        chk(prog_strobe == '0, "R1 strobe", prog_strobe, 0);
        chk_wear("R1 wear");
        rst_n = 1'b1;
        tick;

        // R2 R3 R5 R8: repeated write-backs through saturation
        for (int n = 0; n < 10; n++) begin
            d = NL*BW'(32'h135 * (n + 1) ^ 32'hA5C3F0);
            shadow_in = d;
            pulse;
            chk(busy == 1'b1, "R2 busy rise", busy, 1);
            measure(d);
            chk_wear("R8 wear");
            tick;
            chk(busy == 1'b0 && prog_strobe == '0, "R7 stays idle", busy, 0);
        end

        // R4: gate sweep over wait lengths
        for (int w = 0; w < 4; w++) begin
            d = NL*BW'(32'h5A0000 + w);
            shadow_in = d;
            zc_enable = 1'b1;
            zc_done = 1'b0;
            pulse;
            for (int k = 0; k < w + 1; k++) begin
                chk(busy == 1'b1 && prog_strobe == '0, "R4 waiting", {busy, prog_strobe}, 4'b1000);
                if (k < w) tick;
            end
            zc_done = 1'b1;
            tick;
            measure(d);
            zc_enable = 1'b0;
            zc_done = 1'b0;
            tick;
        end
        // R4: zc_done ignored when not enabled
        d = 24'h00C0DE;
        shadow_in = d;
        pulse;
        chk(prog_strobe == '1, "R4 disabled gate", prog_strobe, 3'b111);
        measure(d);
        tick;

        // R6 R7: strobe at each busy position, extra pulse at position 1
        for (int p = 0; p < WC; p++) begin
            d = NL*BW'(32'h111111 * (p + 1));
            shadow_in = d;
            pulse;
            for (int k = 0; k < p; k++) tick;
            wr_done = 1'b1;
            tick;
            if (p == 1) tick;
            wr_done = 1'b0;
            for (int k = 0; k < 20 && busy; k++) tick;
            nwb++;
            lows = 0;
            for (int k = 0; k < 20 && !busy; k++) begin
                lows++;
                tick;
            end
            chk(lows == 1, "R6 gap", lows, 1);
            d = shadow_in;
            chk(prog_strobe == '1, "R6 latched start", prog_strobe, 3'b111);
            nwb--;
            measure(d);
            for (int k = 0; k < 5; k++) begin
                if (busy) chk(0, "R7 one extra only", busy, 0);
                tick;
            end
            chk(busy == 1'b0, "R7 idle after", busy, 0);
            chk_wear("R8 wear after pending");
        end
        done = 1'b1;
    end

    initial begin
        for (int c = 0; c < 20000 && !done; c++) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=hung expected=done");
        end
        #3;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule